// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block turns a serial bit stream on `rxd` into parallel words of up to nine bits. In the asynchronous formats it looks for a start bit using a 16x oversampling enable `tick16`. It then collects 7, 8 or 9 data bits, an optional parity bit and one or two stop bits. In the synchronous format it shifts exactly eight bits, one on each selected edge of an external serial clock `sclk`. Both `rxd` and `sclk` pass through a resynchronizer first.

Every format setting is a static input that the system changes only while the port is off. These settings are the frame format, parity sense, stop count, line polarity, data inversion and bit order. Each finished word goes into a one-entry receive buffer, together with its parity, framing and overrun flags, and `rx_valid` pulses for one cycle. The consumer frees the buffer with `rd_ack`. An active-low ready output `rts_n` can advertise whether the buffer can accept another word.

Top module: `serframe_rx`

## Requirements
- R1: `mode_sel` 3'b100, 3'b101 and 3'b110 select asynchronous frames of 7, 8 and 9 data bits. The data bits arrive least significant first. Word bits at or above the data length read 0.
- R2: A start is seen when the line, sampled on `tick16`, falls from 1 to 0. It is accepted only if the line is still 0 eight ticks later. A low pulse shorter than that produces no word.
- R3: With `par_en`=1 in an asynchronous format, one parity bit follows the data. `err_parity` is 1 when the XOR of the data and parity bits differs from `par_odd` (0 = even, 1 = odd). With `par_en`=0 no parity bit is expected and `err_parity` is 0.
- R4: `err_frame` is 1 when the first stop bit samples 0. With `two_stop`=1 a second stop period is waited out but never checked.
- R5: With `line_inv`=1, `rxd` is inverted before any other processing, in every format.
- R6: With `msb_first`=1, the first data bit received lands in word bit n-1 instead of bit 0. With `data_inv`=1, the n data bits of the word are inverted. Zero-filled upper bits are never inverted.
- R7: `mode_sel`=3'b001 shifts exactly 8 bits, least significant first. It samples on rising `sclk` edges when `sclk_fall`=0 and on falling edges when `sclk_fall`=1. Parity and stop settings are ignored, and both error flags read 0.
- R8: `rx_valid` is a one-cycle pulse in the cycle a new word appears. `rx_word` and the flags hold their values until the next word.
- R9: `err_overrun` is 1 on a word that arrived while the previous word was unacknowledged. A one-cycle `rd_ack` frees the buffer.
- R10: With `rts_en`=1, `rts_n` is 0 while the port is on and the buffer is free, and 1 otherwise. With `rts_en`=0, `rts_n` is 0.
- R11: `mode_sel`=3'b000, and any code not listed above, turns the port off: no word is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Format select |
| par_en | input | 1 | Parity bit present (asynchronous) |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| two_stop | input | 1 | Two stop bits (asynchronous) |
| line_inv | input | 1 | Invert incoming line |
| data_inv | input | 1 | Invert received data bits |
| msb_first | input | 1 | Reverse bit order of the word |
| sclk_fall | input | 1 | Synchronous mode samples on falling sclk edge |
| rts_en | input | 1 | Enable ready output |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial data line |
| sclk | input | 1 | External serial clock (synchronous mode) |
| rd_ack | input | 1 | Consumer has taken the word |
| rx_word | output | 9 | Received word, zero-extended |
| rx_valid | output | 1 | New word strobe |
| err_parity | output | 1 | Parity mismatch on current word |
| err_frame | output | 1 | First stop bit was low |
| err_overrun | output | 1 | Current word overwrote an unread word |
| rts_n | output | 1 | Active-low ready to receive |

## Verification
The assertions watch several properties on every cycle. They check that the strobe lasts one cycle, that the word holds steady between strobes, and that the top bit is zero outside the 9-bit format. They also check that the ready output is high whenever a word lands with the ready output enabled, and that nothing arrives while the port is off. Finally, they check that the overrun flag only rises with a new word, and that the error flags stay clear in the synchronous format and when parity is off. The bench scenarios are needed for everything else. These include the bit placement under every combination of length, parity, stop count, polarity, inversion and order, and both sampling edges in the synchronous format. They also cover the rejection of short start pulses, the injected parity and stop errors, and the overrun-then-recover sequence.

// File: rtl/serframe_pkg.sv
package serframe_pkg;

   localparam logic [2:0] MODE_OFF  = 3'b000;
   localparam logic [2:0] MODE_SYNC = 3'b001;
   localparam logic [2:0] MODE_A7   = 3'b100;
   localparam logic [2:0] MODE_A8   = 3'b101;
   localparam logic [2:0] MODE_A9   = 3'b110;

   localparam int WORD_W = 9;

   typedef struct packed {
      logic [WORD_W-1:0] raw;
      logic [3:0]        nbits;
      logic              perr;
      logic              ferr;
   } frame_t;

   function automatic logic is_async(input logic [2:0] m);
      return (m == MODE_A7) || (m == MODE_A8) || (m == MODE_A9);
   endfunction

   function automatic logic [3:0] data_bits(input logic [2:0] m);
      case (m)
         MODE_A7: return 4'd7;
         MODE_A9: return 4'd9;
         default: return 4'd8;
      endcase
   endfunction

   // place raw bits into the word: optional order reversal and inversion
   function automatic logic [WORD_W-1:0] shape_word(input logic [WORD_W-1:0] raw,
                                                     input logic [3:0] n,
                                                     input logic rev,
                                                     input logic inv);
      logic [WORD_W-1:0] w;
      w = '0;
      for (int i = 0; i < WORD_W; i++) begin
         if (i < int'(n)) begin
            w[i] = (rev ? raw[int'(n) - 1 - i] : raw[i]) ^ inv;
         end
      end
      return w;
   endfunction

endpackage

// File: rtl/serframe_front.sv
module serframe_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rxd,
   input  logic sclk,
   input  logic line_inv,
   input  logic sclk_fall,
   output logic line,
   output logic samp_edge
);

   logic rxd_s;
   logic sclk_s;
   logic sclk_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxd_s  = rxd;
         assign sclk_s = sclk;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] rx_q;
         logic [SYNC_STAGES-1:0] ck_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rx_q <= '0;
               ck_q <= '0;
            end else begin
               rx_q[0] <= rxd;
               ck_q[0] <= sclk;
               for (int k = 1; k < SYNC_STAGES; k++) begin
                  rx_q[k] <= rx_q[k-1];
                  ck_q[k] <= ck_q[k-1];
               end
            end
         end
         assign rxd_s  = rx_q[SYNC_STAGES-1];
         assign sclk_s = ck_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign line      = rxd_s ^ line_inv;
   assign samp_edge = sclk_fall ? (sclk_prev & ~sclk_s) : (~sclk_prev & sclk_s);

endmodule

// File: rtl/serframe_async.sv
module serframe_async
   import serframe_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       line,
   input  logic [3:0] nbits,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       two_stop,
   output logic       done,
   output frame_t     frame
);

   localparam int          CW   = $clog2(OVS);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   typedef enum logic [1:0] {A_IDLE, A_START, A_BITS, A_STOP2} ast_e;

   ast_e              st;
   logic [CW-1:0]     cnt;
   logic [3:0]        idx;
   logic [WORD_W-1:0] raw;
   logic              acc;
   logic              prev;
   logic [3:0]        stop_idx;
   logic              bit_pt;

   assign stop_idx = nbits + {3'b000, par_en};
   assign bit_pt   = tick && (st == A_BITS) && (cnt == LAST);
   assign done     = en && bit_pt && (idx == stop_idx);

   always_comb begin
      frame.raw   = raw;
      frame.nbits = nbits;
      frame.perr  = par_en && (acc != par_odd);
      frame.ferr  = !line;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= A_IDLE;
         cnt  <= '0;
         idx  <= '0;
         raw  <= '0;
         acc  <= 1'b0;
         prev <= 1'b0;
      end else begin
         if (tick) prev <= line;
         if (!en) begin
            st  <= A_IDLE;
            cnt <= '0;
         end else if (tick) begin
            case (st)
               A_IDLE: begin
                  if (prev && !line) begin
                     st  <= A_START;
                     cnt <= '0;
                  end
               end
               A_START: begin
                  if (cnt == MID) begin
                     cnt <= '0;
                     if (!line) begin
                        st  <= A_BITS;
                        idx <= '0;
                        raw <= '0;
                        acc <= 1'b0;
                     end else begin
                        st <= A_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               A_BITS: begin
                  if (cnt == LAST) begin
                     cnt <= '0;
                     idx <= idx + 1'b1;
                     if (idx < nbits) begin
                        raw[idx] <= line;
                        acc      <= acc ^ line;
                     end else if (idx != stop_idx) begin
                        acc <= acc ^ line;
                     end else begin
                        st <= two_stop ? A_STOP2 : A_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               A_STOP2: begin
                  if (cnt == LAST) st <= A_IDLE;
                  else             cnt <= cnt + 1'b1;
               end
               default: st <= A_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/serframe_sync.sv
module serframe_sync
   import serframe_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   en,
   input  logic   edge_i,
   input  logic   line,
   output logic   done,
   output frame_t frame
);

   logic [2:0] cnt;
   logic [6:0] raw;

   assign done = en && edge_i && (cnt == 3'd7);

   always_comb begin
      frame.raw   = {1'b0, line, raw};
      frame.nbits = 4'd8;
      frame.perr  = 1'b0;
      frame.ferr  = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         raw <= '0;
      end else if (!en) begin
         cnt <= '0;
      end else if (edge_i) begin
         if (cnt != 3'd7) raw[cnt] <= line;
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/serframe_buf.sv
module serframe_buf
   import serframe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_done,
   input  frame_t            a_frame,
   input  logic              s_done,
   input  frame_t            s_frame,
   input  logic              msb_first,
   input  logic              data_inv,
   input  logic              rd_ack,
   input  logic              rts_en,
   input  logic              port_on,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              err_parity,
   output logic              err_frame,
   output logic              err_overrun,
   output logic              rts_n
);

   frame_t f_sel;
   logic   full;

   assign f_sel = a_done ? a_frame : s_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word     <= '0;
         rx_valid    <= 1'b0;
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
         full        <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (a_done || s_done) begin
            rx_word     <= shape_word(f_sel.raw, f_sel.nbits, msb_first, data_inv);
            err_parity  <= f_sel.perr;
            err_frame   <= f_sel.ferr;
            err_overrun <= full && !rd_ack;
            full        <= 1'b1;
            rx_valid    <= 1'b1;
         end else if (rd_ack) begin
            full <= 1'b0;
         end
      end
   end

   assign rts_n = rts_en ? (full | ~port_on) : 1'b0;

endmodule

// File: rtl/serframe_rx.sv
module serframe_rx
   import serframe_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int OVS         = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_sel,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       two_stop,
   input  logic       line_inv,
   input  logic       data_inv,
   input  logic       msb_first,
   input  logic       sclk_fall,
   input  logic       rts_en,
   input  logic       tick16,
   input  logic       rxd,
   input  logic       sclk,
   input  logic       rd_ack,
   output logic [8:0] rx_word,
   output logic       rx_valid,
   output logic       err_parity,
   output logic       err_frame,
   output logic       err_overrun,
   output logic       rts_n
);

   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("serframe_rx: OVS must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("serframe_rx: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic   line;
   logic   samp_edge;
   logic   a_en, s_en, port_on;
   logic   a_done, s_done;
   frame_t a_frame, s_frame;

   assign a_en    = is_async(mode_sel);
   assign s_en    = (mode_sel == MODE_SYNC);
   assign port_on = a_en | s_en;

   serframe_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .rxd       (rxd),
      .sclk      (sclk),
      .line_inv  (line_inv),
      .sclk_fall (sclk_fall),
      .line      (line),
      .samp_edge (samp_edge)
   );

   serframe_async #(.OVS(OVS)) u_async (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (a_en),
      .tick     (tick16),
      .line     (line),
      .nbits    (data_bits(mode_sel)),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .two_stop (two_stop),
      .done     (a_done),
      .frame    (a_frame)
   );

   serframe_sync u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (s_en),
      .edge_i (samp_edge),
      .line   (line),
      .done   (s_done),
      .frame  (s_frame)
   );

   serframe_buf u_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .a_done      (a_done),
      .a_frame     (a_frame),
      .s_done      (s_done),
      .s_frame     (s_frame),
      .msb_first   (msb_first),
      .data_inv    (data_inv),
      .rd_ack      (rd_ack),
      .rts_en      (rts_en),
      .port_on     (port_on),
      .rx_word     (rx_word),
      .rx_valid    (rx_valid),
      .err_parity  (err_parity),
      .err_frame   (err_frame),
      .err_overrun (err_overrun),
      .rts_n       (rts_n)
   );

endmodule

// File: rtl/serframe_rx_chk.sv
module serframe_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode_sel,
   input logic       par_en,
   input logic       rts_en,
   input logic [8:0] rx_word,
   input logic       rx_valid,
   input logic       err_parity,
   input logic       err_frame,
   input logic       err_overrun,
   input logic       rts_n
);

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);  // R8

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_word));  // R8

   AST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && mode_sel != 3'b110) |-> !rx_word[8]);  // R1

   AST_RTS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rts_en) |-> rts_n);  // R10

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_sel) == 3'b000) |-> !rx_valid);  // R11

   AST_OVR_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_overrun) |-> rx_valid);  // R9

   AST_SYNC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && $past(mode_sel) == 3'b001) |-> (!err_parity && !err_frame));  // R7

   AST_NOPAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !par_en) |-> !err_parity);  // R3

endmodule

bind serframe_rx serframe_rx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_sel    (mode_sel),
   .par_en      (par_en),
   .rts_en      (rts_en),
   .rx_word     (rx_word),
   .rx_valid    (rx_valid),
   .err_parity  (err_parity),
   .err_frame   (err_frame),
   .err_overrun (err_overrun),
   .rts_n       (rts_n)
);

// File: tb/serframe_rx_bench.sv
`timescale 1ns/1ps
module serframe_rx_bench;

   localparam int BITCLK = 32;   // 16 ticks, one tick every 2 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_sel = 3'b000;
   logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
   logic       line_inv = 1'b0, data_inv = 1'b0, msb_first = 1'b0;
   logic       sclk_fall = 1'b0, rts_en = 1'b1;
   logic       tick16 = 1'b0, rxd = 1'b1, sclk = 1'b0, rd_ack = 1'b0;
   logic [8:0] rx_word;
   logic       rx_valid, err_parity, err_frame, err_overrun, rts_n;

   int checks = 0;
   int errors = 0;
   int vcount = 0;
   logic [8:0] cap_word = '0;
   logic [2:0] cap_flags = '0;

   serframe_rx u_serframe_rx (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .par_en(par_en),
      .par_odd(par_odd), .two_stop(two_stop), .line_inv(line_inv),
      .data_inv(data_inv), .msb_first(msb_first), .sclk_fall(sclk_fall),
      .rts_en(rts_en), .tick16(tick16), .rxd(rxd), .sclk(sclk),
      .rd_ack(rd_ack), .rx_word(rx_word), .rx_valid(rx_valid),
      .err_parity(err_parity), .err_frame(err_frame),
      .err_overrun(err_overrun), .rts_n(rts_n)
   );

   initial forever #2.5 clk = ~clk;

   initial forever begin
      @(negedge clk);
      tick16 = ~tick16;
   end

   initial forever begin
      @(negedge clk);
      if (rx_valid) begin
         vcount++;
         cap_word  = rx_word;
         cap_flags = {err_parity, err_frame, err_overrun};
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [8:0] exp_word(input logic [8:0] d, input int n,
                                           input logic rev, input logic inv);
      logic [8:0] w;
      w = '0;
      for (int i = 0; i < n; i++) w[i] = d[rev ? (n - 1 - i) : i] ^ inv;
      return w;
   endfunction

   task automatic send_bit(input logic b);
      rxd = b ^ line_inv;
      wait_clks(BITCLK);
   endtask

   task automatic send_async(input logic [8:0] d, input int n, input logic bad_par,
                             input logic stop1_low, input logic stop2_low);
      logic p;
      p = 1'b0;
      send_bit(1'b0);
      for (int i = 0; i < n; i++) begin
         send_bit(d[i]);
         p = p ^ d[i];
      end
      if (par_en) send_bit(p ^ par_odd ^ bad_par);
      send_bit(!stop1_low);
      if (two_stop) send_bit(!stop2_low);
      rxd = ~line_inv;
      wait_clks(48);
   endtask

   task automatic send_sync(input logic [7:0] d);
      for (int i = 0; i < 8; i++) begin
         rxd = d[i] ^ line_inv;
         wait_clks(4);
         sclk = ~sclk_fall;
         wait_clks(4);
         sclk = sclk_fall;
         wait_clks(4);
      end
      wait_clks(8);
   endtask

   task automatic set_mode(input logic [2:0] m);
      mode_sel = 3'b000;
      rxd = ~line_inv;
      sclk = sclk_fall;
      wait_clks(40);
      mode_sel = m;
      wait_clks(8);
   endtask

   task automatic ack();
      rd_ack = 1'b1;
      wait_clks(1);
      rd_ack = 1'b0;
      wait_clks(1);
   endtask

   task automatic expect_word(input string req, input int v0, input logic [8:0] w,
                              input logic [2:0] flags);
      #1;
      chk(req, "count", 16'(vcount), 16'(v0 + 1));
      chk(req, "word", {7'd0, cap_word}, {7'd0, w});
      chk(req, "flags", {13'd0, cap_flags}, {13'd0, flags});
   endtask

   initial begin
      int v0;
      logic [8:0] d;
      wait_clks(10);
      rst_n = 1'b1;
      wait_clks(2);
      #1;
      // reset state; port off so ready is high (R10, R11)
      chk("R8", "reset word", {7'd0, rx_word}, 16'd0);
      chk("R8", "reset valid", {15'd0, rx_valid}, 16'd0);
      chk("R9", "reset flags", {13'd0, err_parity, err_frame, err_overrun}, 16'd0);
      chk("R10", "reset rts_n", {15'd0, rts_n}, 16'd1);

      // asynchronous sweep: R1 R3 R4 R5 R6 R8 R10
      for (int k = 0; k < 96; k++) begin
         int n;
         n         = 7 + (k % 3);
         par_en    = k[2];
         two_stop  = k[3];
         line_inv  = k[4];
         data_inv  = k[5];
         msb_first = k[6];
         par_odd   = k[0] ^ k[3];
         rts_en    = k[1];
         set_mode(3'b100 + 3'(k % 3));
         d = 9'((k * 73 + 29) & ((1 << n) - 1));
         v0 = vcount;
         send_async(d, n, 1'b0, 1'b0, 1'b0);
         expect_word("R1", v0, exp_word(d, n, msb_first, data_inv), 3'b000);
         chk("R10", "rts_n full", {15'd0, rts_n}, {15'd0, rts_en});
         ack();
         #1;
         chk("R10", "rts_n free", {15'd0, rts_n}, 16'd0);
      end

      // parity errors, even and odd (R3)
      line_inv = 0; data_inv = 0; msb_first = 0; two_stop = 0; par_en = 1; rts_en = 1;
      for (int po = 0; po < 2; po++) begin
         par_odd = po[0];
         set_mode(3'b101);
         v0 = vcount;
         send_async(9'h0A5, 8, 1'b1, 1'b0, 1'b0);
         expect_word("R3", v0, 9'h0A5, 3'b100);
         ack();
      end

      // framing error on first stop bit (R4)
      par_en = 0;
      set_mode(3'b101);
      v0 = vcount;
      send_async(9'h03C, 8, 1'b0, 1'b1, 1'b0);
      expect_word("R4", v0, 9'h03C, 3'b010);
      ack();

      // low second stop bit is not checked (R4)
      two_stop = 1;
      set_mode(3'b110);
      v0 = vcount;
      send_async(9'h1C3, 9, 1'b0, 1'b0, 1'b1);
      expect_word("R4", v0, 9'h1C3, 3'b000);
      wait_clks(600);
      #1;
      chk("R4", "no extra word", 16'(vcount), 16'(v0 + 1));
      ack();
      two_stop = 0;

      // short low pulse rejected, then a good frame (R2)
      set_mode(3'b101);
      v0 = vcount;
      rxd = 1'b0;
      wait_clks(6);
      rxd = 1'b1;
      wait_clks(600);
      #1;
      chk("R2", "glitch ignored", 16'(vcount), 16'(v0));
      send_async(9'h081, 8, 1'b0, 1'b0, 1'b0);
      expect_word("R2", v0, 9'h081, 3'b000);
      ack();

      // overrun and recovery (R9)
      v0 = vcount;
      send_async(9'h011, 8, 1'b0, 1'b0, 1'b0);
      expect_word("R9", v0, 9'h011, 3'b000);
      v0 = vcount;
      send_async(9'h022, 8, 1'b0, 1'b0, 1'b0);
      expect_word("R9", v0, 9'h022, 3'b001);
      ack();
      v0 = vcount;
      send_async(9'h044, 8, 1'b0, 1'b0, 1'b0);
      expect_word("R9", v0, 9'h044, 3'b000);

      // ready disabled stays low while full (R10)
      rts_en = 0;
      wait_clks(2);
      #1;
      chk("R10", "rts off", {15'd0, rts_n}, 16'd0);
      ack();
      rts_en = 1;

      // port off: codes 000 and 111 receive nothing (R11)
      for (int c = 0; c < 2; c++) begin
         set_mode(c == 0 ? 3'b000 : 3'b111);
         v0 = vcount;
         send_async(9'h055, 8, 1'b0, 1'b0, 1'b0);
         #1;
         chk("R11", "no word when off", 16'(vcount), 16'(v0));
         chk("R10", "rts_n off", {15'd0, rts_n}, 16'd1);
      end

      // synchronous sweep over edge, polarity, inversion, order (R7 R5 R6)
      par_en = 1; two_stop = 1;
      for (int k = 0; k < 16; k++) begin
         sclk_fall = k[0];
         line_inv  = k[1];
         data_inv  = k[2];
         msb_first = k[3];
         set_mode(3'b001);
         d = 9'((k * 151 + 7) & 8'hFF);
         v0 = vcount;
         send_sync(d[7:0]);
         expect_word("R7", v0, exp_word(d, 8, msb_first, data_inv), 3'b000);
         ack();
      end

      set_mode(3'b000);
      finish_run();
   end

endmodule